// File: doc/BRIEF.md
# Ethernet MAC Frame Generator

This block turns a start request and a set of configuration inputs into one complete Ethernet MAC frame, delivered as a stream of bytes, one byte per clock. Each frame may open with a seven-byte preamble, then carries the start frame delimiter, the destination and source addresses, the 16-bit length/type field, the payload, any zero padding needed to reach the minimum frame size, and a four-byte frame check sequence that is computed while the bytes stream out.

The payload comes from one of two sources. The first is an internal counting pattern. The second is an external byte input that the block reads through a take strobe. The block works out the payload size from the length/type field. Oversized requests are cut to the largest legal payload and flagged. After each frame the block enforces an idle gap before the next one begins. A start request that arrives while a frame or gap is in progress is remembered and served afterwards. Configuration is captured at the moment a request is accepted.

Top module: `eth_frame_gen`

## Requirements
- R1: While reset is held and after it is released with no start request, tx_valid, tx_sof, tx_eof and ext_take are all low.
- R2: With cfg_pre_en high, the frame opens with seven bytes of 0x55 followed by 0xD5. With it low, the frame opens with 0xD5. tx_sof is high only on the first byte of the frame.
- R3: Six destination address bytes follow the delimiter, cfg_dst[47:40] first. tx_mcast equals cfg_dst[40], the lowest bit of the first address byte, throughout the frame.
- R4: Six source address bytes follow, cfg_src[47:40] first. They are followed by the two length/type bytes, cfg_lt[15:8] first.
- R5: A cfg_lt value of 1536 or more is a type, and the payload size is then cfg_pay_len. A cfg_lt value below 1536 is a length, and it alone sets the payload size.
- R6: A payload request above 1500 is cut to 1500 bytes, and tx_clamped is high for that frame. It is low for frames that are not cut.
- R7: When the payload is shorter than 46 bytes, zero bytes follow it until payload plus padding is 46 bytes.
- R8: With cfg_ext_pay low, payload byte i is i modulo 256. With it high, each payload byte is the value of ext_data in the cycle where ext_take is high. ext_take is high for exactly one cycle per payload byte.
- R9: The last four bytes are the complemented reflected CRC-32 (polynomial 0xEDB88320 in reflected form, initial value all ones), least significant byte first. The CRC covers the bytes from the destination address through the padding. Running the same CRC, without the final complement, over the bytes from the destination address through the FCS leaves 0xDEBB20E3.
- R10: tx_eof is high on the last FCS byte only. The frame from the destination address through the FCS is 64 to 1518 bytes long.
- R11: At least 12 cycles with tx_valid low separate tx_eof from the next tx_sof. A start pulse received during a frame or gap produces one further frame once the gap has passed.
- R12: Within a frame, tx_valid stays high in every cycle from tx_sof to tx_eof.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request one frame |
| cfg_pre_en | input | 1 | Emit the seven-byte preamble |
| cfg_ext_pay | input | 1 | Take payload from ext_data instead of the counting pattern |
| cfg_dst | input | 48 | Destination address, first byte in [47:40] |
| cfg_src | input | 48 | Source address, first byte in [47:40] |
| cfg_lt | input | 16 | Length/type field value |
| cfg_pay_len | input | 16 | Payload size used when cfg_lt is a type |
| ext_data | input | 8 | External payload byte |
| ext_take | output | 1 | ext_data is consumed this cycle |
| tx_data | output | 8 | Frame byte |
| tx_valid | output | 1 | tx_data carries a frame byte |
| tx_sof | output | 1 | First byte of a frame |
| tx_eof | output | 1 | Last byte of a frame |
| tx_mcast | output | 1 | Destination address of this frame is a group address |
| tx_clamped | output | 1 | Payload request of this frame was cut to 1500 |

## Verification
A wrong field counter or state shows up at the ports as a shifted or resized frame. The captured byte image then diverges from the expected frame at the first misplaced byte, and the frame ends at the wrong length. A corrupted CRC register is invisible until the four FCS bytes arrive. There it breaks both the direct FCS comparison and the residue check for that same frame. Faults in the gap counter or the held request show up only on back-to-back starts, as a short idle gap or a missing second frame.

// File: rtl/eth_frame_gen.sv
module eth_frame_gen #(
  parameter int PRE_LEN  = 7,
  parameter int GAP_LEN  = 12,
  parameter int MAX_PAY  = 1500,
  parameter int MIN_PAY  = 46,
  parameter int TYPE_MIN = 1536
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        cfg_pre_en,
  input  logic        cfg_ext_pay,
  input  logic [47:0] cfg_dst,
  input  logic [47:0] cfg_src,
  input  logic [15:0] cfg_lt,
  input  logic [15:0] cfg_pay_len,
  input  logic [7:0]  ext_data,
  output logic        ext_take,
  output logic [7:0]  tx_data,
  output logic        tx_valid,
  output logic        tx_sof,
  output logic        tx_eof,
  output logic        tx_mcast,
  output logic        tx_clamped
);
  localparam int CW = $clog2(MAX_PAY + 1);
  localparam logic [31:0] POLY = 32'hEDB88320;

  typedef enum logic [3:0] {S_IDLE, S_PRE, S_SFD, S_DA, S_SA, S_LT, S_PAY, S_PAD, S_FCS, S_GAP} st_t;

  st_t          st;
  logic [CW-1:0] cnt, pay_n, pad_n;
  logic [47:0]  da, sa;
  logic [15:0]  lt;
  logic         ext_q, first, pend;
  logic [31:0]  crc;

  logic [15:0]  req;
  logic         over;
  logic [CW-1:0] eff, padc;
  assign req  = (cfg_lt >= 16'(TYPE_MIN)) ? cfg_pay_len : cfg_lt;
  assign over = req > 16'(MAX_PAY);
  assign eff  = over ? CW'(MAX_PAY) : req[CW-1:0];
  assign padc = (eff < CW'(MIN_PAY)) ? CW'(MIN_PAY) - eff : '0;

  logic accept;
  assign accept = (st == S_IDLE) && (start || pend);

  logic [7:0] cur;
  always_comb begin
    case (st)
      S_PRE:   cur = 8'h55;
      S_SFD:   cur = 8'hD5;
      S_DA:    cur = 8'(da >> (8 * (5 - int'(cnt))));
      S_SA:    cur = 8'(sa >> (8 * (5 - int'(cnt))));
      S_LT:    cur = cnt[0] ? lt[7:0] : lt[15:8];
      S_PAY:   cur = ext_q ? ext_data : cnt[7:0];
      S_FCS:   cur = ~crc[8*cnt[1:0] +: 8];
      default: cur = 8'h00;
    endcase
  end

  logic active, in_crc;
  assign active   = (st != S_IDLE) && (st != S_GAP);
  assign in_crc   = (st == S_DA) || (st == S_SA) || (st == S_LT) || (st == S_PAY) || (st == S_PAD);
  assign ext_take = (st == S_PAY) && ext_q;

  function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int b = 0; b < 8; b++)
      r = (r >> 1) ^ (POLY & {32{r[0] ^ d[b]}});
    return r;
  endfunction

  logic last;
  always_comb begin
    case (st)
      S_PRE:   last = cnt == CW'(PRE_LEN - 1);
      S_SFD:   last = 1'b1;
      S_DA,
      S_SA:    last = cnt == CW'(5);
      S_LT:    last = cnt == CW'(1);
      S_PAY:   last = cnt == pay_n - 1'b1;
      S_PAD:   last = cnt == pad_n - 1'b1;
      S_FCS:   last = cnt == CW'(3);
      S_GAP:   last = cnt == CW'(GAP_LEN - 1);
      default: last = 1'b0;
    endcase
  end

  st_t after_lt, after_pay;
  assign after_pay = (pad_n != '0) ? S_PAD : S_FCS;
  assign after_lt  = (pay_n != '0) ? S_PAY : after_pay;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cnt <= '0;
      pend <= 1'b0;
      first <= 1'b0;
      crc <= '1;
      da <= '0; sa <= '0; lt <= '0;
      pay_n <= '0; pad_n <= '0; ext_q <= 1'b0;
      tx_mcast <= 1'b0;
      tx_clamped <= 1'b0;
    end else begin
      if (accept) pend <= 1'b0;
      else if (start) pend <= 1'b1;
      if (in_crc) crc <= crc_byte(crc, cur);
      if (active) first <= 1'b0;
      if (accept) begin
        st <= cfg_pre_en ? S_PRE : S_SFD;
        cnt <= '0;
        first <= 1'b1;
        crc <= '1;
        da <= cfg_dst; sa <= cfg_src; lt <= cfg_lt;
        pay_n <= eff; pad_n <= padc; ext_q <= cfg_ext_pay;
        tx_mcast <= cfg_dst[40];
        tx_clamped <= over;
      end else if (st != S_IDLE) begin
        cnt <= last ? '0 : cnt + 1'b1;
        if (last) begin
          case (st)
            S_PRE:   st <= S_SFD;
            S_SFD:   st <= S_DA;
            S_DA:    st <= S_SA;
            S_SA:    st <= S_LT;
            S_LT:    st <= after_lt;
            S_PAY:   st <= after_pay;
            S_PAD:   st <= S_FCS;
            S_FCS:   st <= S_GAP;
            default: st <= S_IDLE;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_data <= '0;
      tx_valid <= 1'b0;
      tx_sof <= 1'b0;
      tx_eof <= 1'b0;
    end else begin
      tx_data  <= active ? cur : 8'h00;
      tx_valid <= active;
      tx_sof   <= active && first;
      tx_eof   <= (st == S_FCS) && last;
    end
  end

  logic [7:0]  a_gap;
  logic [11:0] a_bytes;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_gap <= 8'hFF;
      a_bytes <= '0;
    end else begin
      if (tx_eof) a_gap <= '0;
      else if (!tx_valid && a_gap != 8'hFF) a_gap <= a_gap + 1'b1;
      if (tx_valid) a_bytes <= tx_sof ? 12'd1 : a_bytes + 1'b1;
    end
  end

  p_sof_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_valid) |-> tx_sof);
  p_sof_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_sof |-> (tx_data == 8'h55 || tx_data == 8'hD5));
  p_eof_alone_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_eof |-> tx_valid && !tx_sof);
  p_frame_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_eof |-> a_bytes >= 12'd64 && a_bytes <= 12'd1525);
  p_take_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ext_take |=> tx_valid && !tx_eof);
  p_gap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    tx_sof |-> a_gap >= 8'(GAP_LEN));
endmodule

// File: tb/test_eth_frame_gen.sv
module test_eth_frame_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, cfg_pre_en = 1'b0, cfg_ext_pay = 1'b0;
  logic [47:0] cfg_dst = '0, cfg_src = '0;
  logic [15:0] cfg_lt = '0, cfg_pay_len = '0;
  logic [7:0] ext_data;
  logic ext_take, tx_valid, tx_sof, tx_eof, tx_mcast, tx_clamped;
  logic [7:0] tx_data;

  always #10 clk = ~clk;

  eth_frame_gen i_eth_frame_gen (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_pre_en(cfg_pre_en),
    .cfg_ext_pay(cfg_ext_pay), .cfg_dst(cfg_dst), .cfg_src(cfg_src),
    .cfg_lt(cfg_lt), .cfg_pay_len(cfg_pay_len), .ext_data(ext_data),
    .ext_take(ext_take), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_sof(tx_sof), .tx_eof(tx_eof), .tx_mcast(tx_mcast), .tx_clamped(tx_clamped));

  int ext_idx = 0;
  int cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (ext_take) ext_idx <= ext_idx + 1;
  end
  assign ext_data = 8'(ext_idx * 13 + 5);

  int tests = 0, fails = 0;
  bit finished = 0;
  logic [7:0] got [0:2047];
  logic [7:0] exp_b [0:2047];
  int got_n, exp_n, sof_cyc, eof_cyc;
  bit mc_seen, cl_seen, contig;

  task automatic check(input bit ok, input string req, input string what, input longint act, input longint expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r = c;
    for (int b = 0; b < 8; b++) begin
      if ((r[0] ^ d[b]) == 1'b1) r = (r >> 1) ^ 32'hEDB88320;
      else r = r >> 1;
    end
    return r;
  endfunction

  task automatic collect();
    while (!(tx_valid && tx_sof)) @(negedge clk);
    sof_cyc = cyc; got_n = 0; contig = 1;
    mc_seen = tx_mcast; cl_seen = tx_clamped;
    forever begin
      if (!tx_valid) contig = 0;
      got[got_n] = tx_data; got_n++;
      if (tx_eof || got_n >= 2047) break;
      @(negedge clk);
    end
    eof_cyc = cyc;
    @(negedge clk);
  endtask

  task automatic build(input bit pre, input bit ext, input int base);
    int req, pay, pad, p;
    logic [31:0] c;
    req = (cfg_lt >= 16'd1536) ? int'(cfg_pay_len) : int'(cfg_lt);
    pay = (req > 1500) ? 1500 : req;
    pad = (pay < 46) ? 46 - pay : 0;
    p = 0;
    if (pre) for (int i = 0; i < 7; i++) begin exp_b[p] = 8'h55; p++; end
    exp_b[p] = 8'hD5; p++;
    for (int i = 0; i < 6; i++) begin exp_b[p] = cfg_dst[47-8*i -: 8]; p++; end
    for (int i = 0; i < 6; i++) begin exp_b[p] = cfg_src[47-8*i -: 8]; p++; end
    exp_b[p] = cfg_lt[15:8]; p++;
    exp_b[p] = cfg_lt[7:0]; p++;
    for (int i = 0; i < pay; i++) begin
      exp_b[p] = ext ? 8'((base + i) * 13 + 5) : 8'(i); p++;
    end
    for (int i = 0; i < pad; i++) begin exp_b[p] = 8'h00; p++; end
    c = 32'hFFFFFFFF;
    for (int i = (pre ? 8 : 1); i < p; i++) c = crc_step(c, exp_b[i]);
    c = ~c;
    for (int i = 0; i < 4; i++) begin exp_b[p] = c[8*i +: 8]; p++; end
    exp_n = p;
  endtask

  task automatic verify(input bit pre, input string tag);
    int off, mism, span;
    logic [31:0] r;
    off = pre ? 8 : 1;
    check(got_n == exp_n, "R5/R7", {tag, " length"}, got_n, exp_n);
    mism = -1;
    for (int i = 0; i < exp_n && i < got_n; i++) if (got[i] !== exp_b[i] && mism < 0) mism = i;
    check(mism < 0, "R2/R3/R4/R8", {tag, " first bad byte index"}, mism, -1);
    if (mism >= 0) check(0, "R8", {tag, " byte value"}, got[mism], exp_b[mism]);
    for (int i = 0; i < 4; i++)
      check(got[got_n-4+i] === exp_b[exp_n-4+i], "R9", {tag, " fcs byte"}, got[got_n-4+i], exp_b[exp_n-4+i]);
    r = 32'hFFFFFFFF;
    for (int i = off; i < got_n; i++) r = crc_step(r, got[i]);
    check(r == 32'hDEBB20E3, "R9", {tag, " residue"}, r, 32'hDEBB20E3);
    span = got_n - off;
    check(span >= 64 && span <= 1518, "R10", {tag, " frame span"}, span, 64);
    check(contig, "R12", {tag, " valid contiguous"}, contig, 1);
    check(mc_seen == cfg_dst[40], "R3", {tag, " mcast flag"}, mc_seen, cfg_dst[40]);
  endtask

  task automatic run(input bit pre, input bit ext, input logic [47:0] d, input logic [15:0] l,
                     input logic [15:0] pl, input bit exp_clamp, input string tag);
    int base;
    @(negedge clk);
    cfg_pre_en = pre; cfg_ext_pay = ext; cfg_dst = d; cfg_src = 48'h02_11_22_33_44_55;
    cfg_lt = l; cfg_pay_len = pl;
    base = ext_idx;
    build(pre, ext, base);
    start = 1'b1; @(negedge clk); start = 1'b0;
    collect();
    verify(pre, tag);
    check(cl_seen == exp_clamp, "R6", {tag, " clamp flag"}, cl_seen, exp_clamp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!tx_valid && !tx_sof && !tx_eof && !ext_take, "R1", "outputs in reset", tx_valid, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!tx_valid && !tx_sof && !tx_eof && !ext_take, "R1", "outputs idle after reset", tx_valid, 0);

    // R2 preamble on/off, R5 length vs type, R7 padding, R6 clamp, R8 sources
    run(1, 0, 48'h00_1B_2C_3D_4E_5F, 16'd0,    16'd0,    0, "len0 pre");
    run(0, 0, 48'h01_00_5E_00_00_01, 16'd0,    16'd0,    0, "len0 nopre mcast");
    run(1, 0, 48'h00_1B_2C_3D_4E_5F, 16'd1,    16'd0,    0, "len1");
    run(0, 0, 48'h03_1B_2C_3D_4E_5F, 16'd45,   16'd0,    0, "len45");
    run(1, 0, 48'h00_1B_2C_3D_4E_5F, 16'd46,   16'd0,    0, "len46");
    run(0, 1, 48'h00_1B_2C_3D_4E_5F, 16'd47,   16'd0,    0, "len47 ext");
    run(1, 1, 48'hFF_FF_FF_FF_FF_FF, 16'd300,  16'd9,    0, "len300 ext bcast");
    run(0, 0, 48'h00_1B_2C_3D_4E_5F, 16'd1500, 16'd0,    0, "len1500");
    run(1, 0, 48'h00_1B_2C_3D_4E_5F, 16'd1535, 16'd0,    1, "len1535 clamp");
    run(0, 0, 48'h00_1B_2C_3D_4E_5F, 16'h0800, 16'd20,   0, "type pay20");
    run(1, 1, 48'h01_1B_2C_3D_4E_5F, 16'd1536, 16'd100,  0, "type1536 pay100 ext");
    run(0, 0, 48'h00_1B_2C_3D_4E_5F, 16'h88B5, 16'd1500, 0, "type pay1500");
    run(1, 1, 48'h00_1B_2C_3D_4E_5F, 16'hFFFF, 16'd1501, 1, "type pay1501 clamp ext");
    run(0, 0, 48'h00_1B_2C_3D_4E_5F, 16'h86DD, 16'd0,    0, "type pay0");

    // R11 start held while busy, gap enforced
    begin
      int first_eof;
      @(negedge clk);
      cfg_pre_en = 1; cfg_ext_pay = 0; cfg_dst = 48'h00_AA_BB_CC_DD_EE;
      cfg_lt = 16'd60; cfg_pay_len = 0;
      build(1, 0, 0);
      start = 1'b1; @(negedge clk); start = 1'b0;
      fork
        collect();
        begin repeat (30) @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0; end
      join
      verify(1, "b2b first");
      first_eof = eof_cyc;
      collect();
      verify(1, "b2b second");
      check(sof_cyc - first_eof - 1 >= 12, "R11", "idle gap", sof_cyc - first_eof - 1, 12);
      repeat (60) @(negedge clk);
      check(!tx_valid, "R11", "single held request gives one frame", tx_valid, 0);
    end

    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      finished = 1;
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule